// File: doc/BRIEF.md
# FPGA Module Board-Management Glue

This block is the small piece of management logic that sits next to an FPGA on a plug-in module. It routes an external JTAG chain to one of two places. With the select input high, the chain ends at local logic. With the select input low, the chain passes straight through to the FPGA. The block also holds the FPGA's active-low configuration-start output until three conditions hold together: board reset is released, the sensed 3.3 V rail is good, and power is enabled. It also reports power-good back to the carrier board.

Two status LEDs show the module's phase. A small state machine tracks that phase from the synchronized reset and configuration-done inputs. It has three states:

- `PH_HOLD`: board reset is asserted.
- `PH_CONFIG`: reset is released but configuration is not done.
- `PH_USER`: configuration is done.

The transitions are:

- HOLD_ENTRY: any state goes to `PH_HOLD` when the synchronized reset is low.
- CFG_ENTRY: any state goes to `PH_CONFIG` when reset is high and done is low.
- USER_ENTRY: any state goes to `PH_USER` when reset and done are both high.

In `PH_HOLD` both LEDs are lit. In `PH_CONFIG` both LEDs blink, timed by a free-running prescaler. In `PH_USER` the LEDs show two FPGA-driven pins. The bidirectional user pin is modelled as separate in, out and output-enable signals, and the block only ever reads it.

Top module: `board_mgmt_glue`

## Requirements
- R1: When `jtag_sel_i` is 1, `ext_tdo_o` equals `loc_tdo_i` and the FPGA-side JTAG outputs sit at idle levels: `fpga_tms_o`=1, `fpga_tck_o`=0, `fpga_tdi_o`=1.
- R2: When `jtag_sel_i` is 0, `fpga_tms_o`, `fpga_tck_o` and `fpga_tdi_o` follow `ext_tms_i`, `ext_tck_i` and `ext_tdi_i` combinationally, and `ext_tdo_o` equals `fpga_tdo_i`.
- R3: `prog_n_o` is low whenever the synchronized reset-release, sense-good and power-enable inputs are not all 1. It goes high on the third rising clock edge after all three are stably high at the inputs: two synchronizer stages plus one register.
- R4: `pwr_good_o` is 1 exactly when the two-stage-synchronized `sense_ok_i` and `pwr_en_i` are both 1, two clock edges after the inputs.
- R5: In `PH_HOLD` (reached on the third edge after `board_rst_n_i` is 0), `led_a_o` and `led_b_o` are both 1.
- R6: In `PH_CONFIG` (reset high, `done_i` low, seen three edges earlier), both LEDs equal the blink signal.
- R7: In `PH_USER` (reset and `done_i` both high, seen three edges earlier), `led_a_o` follows `user_pin_i` and `led_b_o` follows `xio_i`, each through a two-flop synchronizer.
- R8: `user_pin_oe_o` and `user_pin_o` are always 0.
- R9: While `rst_n` is low, `prog_n_o`=0, `pwr_good_o`=0, both LEDs are 1 (state `PH_HOLD`), and the blink signal is 0.
- R10: The blink signal starts at 0 after `rst_n` and toggles every HALF = CLK_HZ/(2*BLINK_HZ) clock cycles. After the e-th edge since reset release it equals (e/HALF) mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| jtag_sel_i | input | 1 | JTAG target select: 1 local, 0 FPGA |
| ext_tms_i | input | 1 | External JTAG TMS |
| ext_tck_i | input | 1 | External JTAG TCK |
| ext_tdi_i | input | 1 | External JTAG TDI |
| ext_tdo_o | output | 1 | External JTAG TDO |
| loc_tdo_i | input | 1 | TDO from local logic |
| fpga_tms_o | output | 1 | TMS toward the FPGA |
| fpga_tck_o | output | 1 | TCK toward the FPGA |
| fpga_tdi_o | output | 1 | TDI toward the FPGA |
| fpga_tdo_i | input | 1 | TDO from the FPGA |
| board_rst_n_i | input | 1 | Board reset from carrier, active low |
| sense_ok_i | input | 1 | Sensed 3.3 V rail good |
| pwr_en_i | input | 1 | Power enable from carrier, active high |
| done_i | input | 1 | FPGA configuration done |
| prog_n_o | output | 1 | Configuration start, active low |
| pwr_good_o | output | 1 | Power-good to carrier |
| user_pin_i | input | 1 | FPGA user pin, input side |
| user_pin_o | output | 1 | FPGA user pin, output value (held 0) |
| user_pin_oe_o | output | 1 | FPGA user pin, output enable (held 0) |
| xio_i | input | 1 | Second FPGA-driven status pin |
| led_a_o | output | 1 | Status LED A |
| led_b_o | output | 1 | Status LED B |

## Verification
The bench builds the block with CLK_HZ=40 and BLINK_HZ=2, which gives a half period of ten cycles. Blink toggling during `PH_CONFIG` is therefore observed many times within a short run. The default 50 MHz setting would need millions of cycles per toggle. With the short period, every phase transition is visited alongside several blink edges, as are power drops that pull `prog_n_o` back low and reset re-entry from `PH_USER`.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    // Index of each board input inside the synchronizer vector
    localparam int IDX_RST   = 0;
    localparam int IDX_DONE  = 1;
    localparam int IDX_SENSE = 2;
    localparam int IDX_EN    = 3;
    localparam int IDX_USER  = 4;
    localparam int IDX_XIO   = 5;
    localparam int N_SYNC    = 6;

    typedef enum logic [1:0] {
        PH_HOLD   = 2'd0,
        PH_CONFIG = 2'd1,
        PH_USER   = 2'd2
    } phase_e;

endpackage

// File: rtl/mgmt_sync.sv
module mgmt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
        end

        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/mgmt_blink.sv
module mgmt_blink #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int BLINK_HZ = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic blink_o
);

    localparam int HALF = (CLK_HZ / (2 * BLINK_HZ)) > 1 ? (CLK_HZ / (2 * BLINK_HZ)) : 2;
    localparam int CW   = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          blink_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            blink_q <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            blink_q <= ~blink_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign blink_o = blink_q;

    // R10
    blink_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_q != $past(blink_q)) |-> ($past(cnt_q) == LAST && cnt_q == '0));

endmodule

// File: rtl/mgmt_jtag_route.sv
module mgmt_jtag_route (
    input  logic sel_local_i,
    input  logic ext_tms_i,
    input  logic ext_tck_i,
    input  logic ext_tdi_i,
    output logic ext_tdo_o,
    input  logic loc_tdo_i,
    output logic fpga_tms_o,
    output logic fpga_tck_o,
    output logic fpga_tdi_o,
    input  logic fpga_tdo_i
);

    always_comb begin
        if (sel_local_i) begin
            fpga_tms_o = 1'b1;
            fpga_tck_o = 1'b0;
            fpga_tdi_o = 1'b1;
            ext_tdo_o  = loc_tdo_i;
        end else begin
            fpga_tms_o = ext_tms_i;
            fpga_tck_o = ext_tck_i;
            fpga_tdi_o = ext_tdi_i;
            ext_tdo_o  = fpga_tdo_i;
        end
    end

endmodule

// File: rtl/mgmt_phase_fsm.sv
module mgmt_phase_fsm
    import mgmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rst_s_i,
    input  logic   done_s_i,
    input  logic   blink_i,
    input  logic   user_s_i,
    input  logic   xio_s_i,
    output phase_e phase_o,
    output logic   led_a_o,
    output logic   led_b_o
);

    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        if (!rst_s_i) begin
            phase_d = PH_HOLD;
        end else if (done_s_i) begin
            phase_d = PH_USER;
        end else begin
            phase_d = PH_CONFIG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_HOLD;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_HOLD: begin
                led_a_o = 1'b1;
                led_b_o = 1'b1;
            end
            PH_CONFIG: begin
                led_a_o = blink_i;
                led_b_o = blink_i;
            end
            PH_USER: begin
                led_a_o = user_s_i;
                led_b_o = xio_s_i;
            end
            default: begin
                led_a_o = 1'b1;
                led_b_o = 1'b1;
            end
        endcase
    end

    assign phase_o = phase_q;

    // R5
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_s_i |=> (phase_q == PH_HOLD));

    // R6
    cfg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_s_i && !done_s_i) |=> (phase_q == PH_CONFIG));

    // R7
    user_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_s_i && done_s_i) |=> (phase_q == PH_USER));

endmodule

// File: rtl/board_mgmt_glue.sv
module board_mgmt_glue
    import mgmt_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int BLINK_HZ = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic jtag_sel_i,
    input  logic ext_tms_i,
    input  logic ext_tck_i,
    input  logic ext_tdi_i,
    output logic ext_tdo_o,
    input  logic loc_tdo_i,
    output logic fpga_tms_o,
    output logic fpga_tck_o,
    output logic fpga_tdi_o,
    input  logic fpga_tdo_i,
    input  logic board_rst_n_i,
    input  logic sense_ok_i,
    input  logic pwr_en_i,
    input  logic done_i,
    output logic prog_n_o,
    output logic pwr_good_o,
    input  logic user_pin_i,
    output logic user_pin_o,
    output logic user_pin_oe_o,
    input  logic xio_i,
    output logic led_a_o,
    output logic led_b_o
);

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] syn;
    logic              blink;
    logic              start_ok;
    logic              prog_q;
    phase_e            phase;

    always_comb begin
        raw_in            = '0;
        raw_in[IDX_RST]   = board_rst_n_i;
        raw_in[IDX_DONE]  = done_i;
        raw_in[IDX_SENSE] = sense_ok_i;
        raw_in[IDX_EN]    = pwr_en_i;
        raw_in[IDX_USER]  = user_pin_i;
        raw_in[IDX_XIO]   = xio_i;
    end

    mgmt_sync #(.WIDTH(N_SYNC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    mgmt_jtag_route u_jtag (
        .sel_local_i (jtag_sel_i),
        .ext_tms_i   (ext_tms_i),
        .ext_tck_i   (ext_tck_i),
        .ext_tdi_i   (ext_tdi_i),
        .ext_tdo_o   (ext_tdo_o),
        .loc_tdo_i   (loc_tdo_i),
        .fpga_tms_o  (fpga_tms_o),
        .fpga_tck_o  (fpga_tck_o),
        .fpga_tdi_o  (fpga_tdi_o),
        .fpga_tdo_i  (fpga_tdo_i)
    );

    mgmt_blink #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .blink_o (blink)
    );

    mgmt_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_s_i  (syn[IDX_RST]),
        .done_s_i (syn[IDX_DONE]),
        .blink_i  (blink),
        .user_s_i (syn[IDX_USER]),
        .xio_s_i  (syn[IDX_XIO]),
        .phase_o  (phase),
        .led_a_o  (led_a_o),
        .led_b_o  (led_b_o)
    );

    // Configuration start gating
    assign start_ok = syn[IDX_RST] & syn[IDX_SENSE] & syn[IDX_EN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= 1'b0;
        end else begin
            prog_q <= start_ok;
        end
    end

    assign prog_n_o      = prog_q;
    assign pwr_good_o    = syn[IDX_SENSE] & syn[IDX_EN];
    assign user_pin_o    = 1'b0;
    assign user_pin_oe_o = 1'b0;

    // R3
    prog_low_on_power_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_o |=> !prog_n_o);

    // R3
    prog_low_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> !prog_n_o);

endmodule

// File: tb/board_mgmt_glue_test.sv
module board_mgmt_glue_test;

    localparam int CLK_HZ   = 40;
    localparam int BLINK_HZ = 2;
    localparam int HALF     = CLK_HZ / (2 * BLINK_HZ);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic jtag_sel = 1'b0, e_tms = 1'b0, e_tck = 1'b0, e_tdi = 1'b0, l_tdo = 1'b0, f_tdo = 1'b0;
    logic b_rst_n = 1'b0, sense = 1'b0, pen = 1'b0, done = 1'b0, upin = 1'b0, xio = 1'b0;
    logic ext_tdo, f_tms, f_tck, f_tdi, prog_n, pgood, up_o, up_oe, led_a, led_b;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    board_mgmt_glue #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .jtag_sel_i(jtag_sel),
        .ext_tms_i(e_tms), .ext_tck_i(e_tck), .ext_tdi_i(e_tdi), .ext_tdo_o(ext_tdo),
        .loc_tdo_i(l_tdo), .fpga_tms_o(f_tms), .fpga_tck_o(f_tck), .fpga_tdi_o(f_tdi),
        .fpga_tdo_i(f_tdo), .board_rst_n_i(b_rst_n), .sense_ok_i(sense), .pwr_en_i(pen),
        .done_i(done), .prog_n_o(prog_n), .pwr_good_o(pgood), .user_pin_i(upin),
        .user_pin_o(up_o), .user_pin_oe_o(up_oe), .xio_i(xio), .led_a_o(led_a), .led_b_o(led_b)
    );

    // Reference model: history of board inputs seen at each rising edge
    typedef struct packed { logic r, d, s, e, u, x; } samp_t;
    samp_t hist[$];
    int    edges;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < 3; i++) hist.push_back('0);
            edges = 0;
        end else begin
            samp_t now;
            now = '{r: b_rst_n, d: done, s: sense, e: pen, u: upin, x: xio};
            hist.push_front(now);
            void'(hist.pop_back());
            edges = edges + 1;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        samp_t q2, q3;
        logic  bl, ea, eb;
        q2 = hist[1];
        q3 = hist[2];
        bl = ((edges / HALF) % 2) == 1;
        if (!rst_n) begin
            chk("R9", "prog_n", prog_n, 1'b0);
            chk("R9", "pgood", pgood, 1'b0);
            chk("R9", "led_a", led_a, 1'b1);
            chk("R9", "led_b", led_b, 1'b1);
        end else begin
            if (!q3.r) begin
                ea = 1'b1; eb = 1'b1;
                chk("R5", "led_a", led_a, ea);
                chk("R5", "led_b", led_b, eb);
            end else if (!q3.d) begin
                chk("R6", "led_a", led_a, bl);
                chk("R6", "led_b", led_b, bl);
                chk("R10", "blink phase", led_a, bl);
            end else begin
                chk("R7", "led_a", led_a, q2.u);
                chk("R7", "led_b", led_b, q2.x);
            end
            chk("R3", "prog_n", prog_n, q3.r & q3.s & q3.e);
            chk("R4", "pgood", pgood, q2.s & q2.e);
        end
        chk("R8", "user_pin_o", up_o, 1'b0);
        chk("R8", "user_pin_oe", up_oe, 1'b0);
        if (jtag_sel) begin
            chk("R1", "ext_tdo", ext_tdo, l_tdo);
            chk("R1", "fpga_tms", f_tms, 1'b1);
            chk("R1", "fpga_tck", f_tck, 1'b0);
            chk("R1", "fpga_tdi", f_tdi, 1'b1);
        end else begin
            chk("R2", "ext_tdo", ext_tdo, f_tdo);
            chk("R2", "fpga_tms", f_tms, e_tms);
            chk("R2", "fpga_tck", f_tck, e_tck);
            chk("R2", "fpga_tdi", f_tdi, e_tdi);
        end
    end

    // Advance n cycles, scrambling the JTAG lines after each rising edge
    task automatic step(int n, bit rnd_user);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            e_tms = 1'($urandom); e_tck = 1'($urandom); e_tdi = 1'($urandom);
            l_tdo = 1'($urandom); f_tdo = 1'($urandom);
            if (rnd_user) begin
                upin = 1'($urandom); xio = 1'($urandom);
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #200_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R9 reset state
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 / R2 JTAG routing, board held in reset (R5)
        jtag_sel = 1'b1; step(25, 1'b1);
        jtag_sel = 1'b0; step(25, 1'b1);
        sense = 1'b1; pen = 1'b1; step(10, 1'b1);
        // R6 configuration phase with blinking, R3 release of prog
        b_rst_n = 1'b1; step(60, 1'b1);
        // R3 power loss restarts configuration
        pen = 1'b0; step(6, 1'b1);
        pen = 1'b1; step(6, 1'b1);
        sense = 1'b0; step(1, 1'b1);
        sense = 1'b1; step(8, 1'b1);
        // R7 user phase
        done = 1'b1; jtag_sel = 1'b1; step(50, 1'b1);
        // R5 reset re-entry from user phase
        b_rst_n = 1'b0; step(12, 1'b1);
        b_rst_n = 1'b1; step(30, 1'b1);
        done = 1'b0; step(30, 1'b1);
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            b_rst_n  = ($urandom % 8) != 0;
            done     = 1'($urandom);
            sense    = ($urandom % 6) != 0;
            pen      = ($urandom % 6) != 0;
            jtag_sel = 1'($urandom);
            step(1 + ($urandom % 5), 1'b1);
        end
        step(5, 1'b0);
        finish_run();
    end

endmodule